// File: doc/BRIEF.md
# Vector element loop sequencer

This block sits between instruction decode and the execution unit. When decode presents a scalar instruction that names one or more registers marked as vectors, the sequencer accepts it, raises `busy` to stall decode and holds the program counter. It then issues one element operation per cycle, until the current vector length is used up. Each element is divided into a group of one to four sub-operations. The sequencer runs that group as an inner loop. Each sub-operation gets register numbers offset from the instruction's base registers.

A per-element predicate mask, captured with the instruction, decides which groups run. A group whose bit is clear is either skipped or, in zeroing mode, turned into one zero write per sub-operation. The execution unit is modelled as a request/response pair. Each response returns a zero-result flag and a fault flag. A fault stops the loop and leaves the element and sub-element offsets pointing at the failing operation. A trap handler can then save those offsets and reload them later, and the next tagged instruction resumes from them. In fail-on-first mode a zero result shortens the vector length and ends the loop early.

The vector length and group size are set through a configuration strobe. Setting them clears the offsets. On normal completion the offsets return to zero and a one-cycle `pc_adv` pulse lets the program counter move on.

Top module: `vec_elem_seq`

## Requirements
- R1: While `busy` is high, `pc_adv` stays low. `pc_adv` pulses for exactly one cycle, in the cycle after the last operation of a loop commits, and at that point `busy` is low.
- R2: For sub-operation s of element e, with group size G = `subvl_cur`+1, each operand whose bit in `dec_vec` is set is issued as its base register plus e*G+s, modulo 128. The bits are rd = bit 0, rs1 = bit 1 and rs2 = bit 2. An operand whose bit is clear keeps its base register.
- R3: An accepted instruction starts at the current `elem_offs` and `sub_offs`, not at zero.
- R4: In non-zeroing mode, a group whose mask bit is clear takes one cycle. During that cycle neither `exec_valid` nor `zero_wr_en` is raised, and the element offset then advances.
- R5: In zeroing mode, a group whose mask bit is clear produces one `zero_wr_en` per sub-operation, one per cycle, with `zero_wr_reg` set to the rd register from R2. `exec_valid` stays low during these cycles.
- R6: A response with `exec_fault` set gives `trap_req` high in the next cycle with `busy` low. `elem_offs` and `sub_offs` still name the faulting operation, and no `pc_adv` is given.
- R7: When a loop completes, `elem_offs` and `sub_offs` are both zero.
- R8: Sub-operations of an element run in order s = 0..G-1 before the next element, and mask bit e of `dec_mask` governs the whole group of element e.
- R9: With `dec_ffirst` set, a zero result from element e ends the loop. `vl_cur` then becomes e, or 1 when e is 0. A zero result without `dec_ffirst` has no effect on the loop.
- R10: With a vector length of 1 and a group size of 1, exactly one operation is issued before `pc_adv`.
- R11: `cfg_en` loads the vector length, clamped to the range 1..MAX_VL, and the group-size code (`cfg_sub`, where G-1 is stored in 2 bits). It also clears both offsets. It acts only while `busy` is low.
- R12: `ld_en` loads the offsets for resumption. The element offset is clamped to `vl_cur`-1 and the sub-element offset to `subvl_cur`. It acts only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Load vector length and group size |
| cfg_vl | input | 4 | Requested vector length |
| cfg_sub | input | 2 | Group size minus one |
| ld_en | input | 1 | Load saved offsets |
| ld_elem | input | 3 | Saved element offset |
| ld_sub | input | 2 | Saved sub-element offset |
| dec_valid | input | 1 | Tagged instruction offered by decode |
| dec_rd | input | 7 | Destination base register |
| dec_rs1 | input | 7 | First source base register |
| dec_rs2 | input | 7 | Second source base register |
| dec_vec | input | 3 | Vector flags for rd, rs1, rs2 |
| dec_mask | input | 8 | Predicate mask, one bit per element |
| dec_zeroing | input | 1 | Zero masked-off elements |
| dec_ffirst | input | 1 | Fail-on-first mode |
| busy | output | 1 | Loop in progress, stalls decode |
| exec_valid | output | 1 | Element operation request |
| exec_rd | output | 7 | Destination register of the request |
| exec_rs1 | output | 7 | First source register of the request |
| exec_rs2 | output | 7 | Second source register of the request |
| exec_resp | input | 1 | Response to the current request |
| exec_zero | input | 1 | Result was zero |
| exec_fault | input | 1 | Operation faulted |
| zero_wr_en | output | 1 | Zero write for a masked-off sub-operation |
| zero_wr_reg | output | 7 | Register receiving the zero |
| pc_adv | output | 1 | Program counter may advance |
| trap_req | output | 1 | Trap request after a fault |
| elem_offs | output | 3 | Current element offset |
| sub_offs | output | 2 | Current sub-element offset |
| vl_cur | output | 4 | Current vector length |
| subvl_cur | output | 2 | Current group size minus one |

## Verification
The assertions assume that the execution side only raises `exec_resp` while `exec_valid` is high. They also assume that `exec_fault` and `exec_zero` carry meaning only in the cycle of that response. They further assume that configuration and offset loads are offered only while `busy` is low. The bench answers each request in the same cycle it appears. It drives all inputs at the falling edge, and it strobes `cfg_en`, `ld_en` and `dec_valid` only between loops. This keeps every run inside those assumptions. Sweeps cover vector lengths 1 to 4, group sizes 1 to 3, several mask patterns, and both zeroing settings. Directed cases then cover fail-on-first, fault and resume, offset clamping and length clamping.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  localparam int unsigned SUB_W = 2;  // group size code width, G-1
  localparam int unsigned N_OPND = 3; // rd, rs1, rs2
endpackage

// File: rtl/vseq_rst_sync.sv
module vseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/vseq_cfg.sv
module vseq_cfg #(
  parameter int unsigned MAX_VL = 8,
  parameter int unsigned VLW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_en,
  input  logic [VLW-1:0]           set_vl,
  input  logic [vseq_pkg::SUB_W-1:0] set_sub,
  input  logic                     cut_en,
  input  logic [VLW-1:0]           cut_vl,
  output logic [VLW-1:0]           vl_q,
  output logic [vseq_pkg::SUB_W-1:0] sub_q
);
  localparam logic [VLW-1:0] VL_TOP = VLW'(MAX_VL);
  localparam logic [VLW-1:0] VL_ONE = VLW'(1);

  logic [VLW-1:0]             vl_d;
  logic [vseq_pkg::SUB_W-1:0] sub_d;
  logic                       vl_ce;

  always_comb begin
    vl_d  = vl_q;
    sub_d = sub_q;
    vl_ce = set_en | cut_en;
    if (set_en) begin
      if (set_vl == '0)         vl_d = VL_ONE;
      else if (set_vl > VL_TOP) vl_d = VL_TOP;
      else                      vl_d = set_vl;
      sub_d = set_sub;
    end else if (cut_en) begin
      vl_d = cut_vl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q  <= VL_ONE;
      sub_q <= '0;
    end else if (vl_ce) begin
      vl_q  <= vl_d;
      sub_q <= sub_d;
    end
  end
endmodule

// File: rtl/vseq_opnd.sv
module vseq_opnd #(
  parameter int unsigned REG_W = 7,
  parameter int unsigned IDXW  = 5
) (
  input  logic [REG_W-1:0] base,
  input  logic             is_vec,
  input  logic [IDXW-1:0]  idx,
  output logic [REG_W-1:0] reg_o
);
  always_comb begin
    if (is_vec) reg_o = base + REG_W'(idx);
    else        reg_o = base;
  end
endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import vseq_pkg::*;
#(
  parameter int unsigned MAX_VL = 8,
  parameter int unsigned VLW    = 4,
  parameter int unsigned OFFW   = 3,
  parameter int unsigned REG_W  = 7,
  parameter int unsigned IDXW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [REG_W-1:0]  dec_rd,
  input  logic [REG_W-1:0]  dec_rs1,
  input  logic [REG_W-1:0]  dec_rs2,
  input  logic [N_OPND-1:0] dec_vec,
  input  logic [MAX_VL-1:0] dec_mask,
  input  logic              dec_zeroing,
  input  logic              dec_ffirst,
  input  logic              cfg_en,
  input  logic              ld_en,
  input  logic [OFFW-1:0]   ld_elem,
  input  logic [SUB_W-1:0]  ld_sub,
  input  logic [VLW-1:0]    vl,
  input  logic [SUB_W-1:0]  sub_code,
  input  logic              exec_resp,
  input  logic              exec_zero,
  input  logic              exec_fault,
  output logic              busy,
  output logic              exec_valid,
  output logic              zero_wr_en,
  output logic [REG_W-1:0]  base_rd,
  output logic [REG_W-1:0]  base_rs1,
  output logic [REG_W-1:0]  base_rs2,
  output logic [N_OPND-1:0] vec_flags,
  output logic [IDXW-1:0]   flat_idx,
  output logic              pc_adv,
  output logic              trap_req,
  output logic [OFFW-1:0]   elem_offs,
  output logic [SUB_W-1:0]  sub_offs,
  output logic              cut_en,
  output logic [VLW-1:0]    cut_vl
);
  seq_state_e        state_q, state_d;
  logic [OFFW-1:0]   e_q, e_d;
  logic [SUB_W-1:0]  s_q, s_d;
  logic [MAX_VL-1:0] mask_q;
  logic              zer_q, ff_q;
  logic [REG_W-1:0]  rd_q, rs1_q, rs2_q;
  logic [N_OPND-1:0] vec_q;
  logic              pc_d, trap_d;
  logic              pc_q, trap_q;

  logic running, grp_on, last_sub, last_elem, grp_end;
  logic step, fault, ff_cut, finish, dec_ce, offs_ce;

  // group-level control derived from the loop state
  always_comb begin
    running   = (state_q == SEQ_RUN);
    grp_on    = mask_q[e_q];
    last_sub  = (s_q == sub_code);
    last_elem = ((VLW'(e_q) + VLW'(1)) == vl);
    grp_end   = (!grp_on && !zer_q) || last_sub;
    step      = running && (grp_on ? exec_resp : 1'b1);
    fault     = running && grp_on && exec_resp && exec_fault;
    ff_cut    = running && grp_on && exec_resp && !exec_fault && ff_q && exec_zero;
    finish    = step && !fault && (ff_cut || (grp_end && last_elem));
    flat_idx  = IDXW'(e_q) * (IDXW'(sub_code) + IDXW'(1)) + IDXW'(s_q);
  end

  // next-state process
  always_comb begin
    state_d = state_q;
    e_d     = e_q;
    s_d     = s_q;
    pc_d    = 1'b0;
    trap_d  = 1'b0;
    dec_ce  = 1'b0;
    offs_ce = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (cfg_en) begin
          e_d     = '0;
          s_d     = '0;
          offs_ce = 1'b1;
        end else if (ld_en) begin
          e_d     = (VLW'(ld_elem) >= vl) ? OFFW'(vl - VLW'(1)) : ld_elem;
          s_d     = (ld_sub > sub_code) ? sub_code : ld_sub;
          offs_ce = 1'b1;
        end
        if (dec_valid) begin
          state_d = SEQ_RUN;
          dec_ce  = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (fault) begin
          state_d = SEQ_IDLE;
          trap_d  = 1'b1;
        end else if (finish) begin
          state_d = SEQ_IDLE;
          e_d     = '0;
          s_d     = '0;
          offs_ce = 1'b1;
          pc_d    = 1'b1;
        end else if (step) begin
          offs_ce = 1'b1;
          if (grp_end) begin
            e_d = e_q + OFFW'(1);
            s_d = '0;
          end else begin
            s_d = s_q + SUB_W'(1);
          end
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      e_q     <= '0;
      s_q     <= '0;
      pc_q    <= 1'b0;
      trap_q  <= 1'b0;
      mask_q  <= '0;
      zer_q   <= 1'b0;
      ff_q    <= 1'b0;
      rd_q    <= '0;
      rs1_q   <= '0;
      rs2_q   <= '0;
      vec_q   <= '0;
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
      trap_q  <= trap_d;
      if (offs_ce) begin
        e_q <= e_d;
        s_q <= s_d;
      end
      if (dec_ce) begin
        mask_q <= dec_mask;
        zer_q  <= dec_zeroing;
        ff_q   <= dec_ffirst;
        rd_q   <= dec_rd;
        rs1_q  <= dec_rs1;
        rs2_q  <= dec_rs2;
        vec_q  <= dec_vec;
      end
    end
  end

  assign busy       = running;
  assign exec_valid = running && grp_on;
  assign zero_wr_en = running && !grp_on && zer_q;
  assign base_rd    = rd_q;
  assign base_rs1   = rs1_q;
  assign base_rs2   = rs2_q;
  assign vec_flags  = vec_q;
  assign pc_adv     = pc_q;
  assign trap_req   = trap_q;
  assign elem_offs  = e_q;
  assign sub_offs   = s_q;
  assign cut_en     = ff_cut;
  assign cut_vl     = (e_q == '0) ? VLW'(1) : VLW'(e_q);
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
  import vseq_pkg::*;
#(
  parameter int unsigned MAX_VL = 8,
  parameter int unsigned REG_W  = 7,
  localparam int unsigned VLW   = $clog2(MAX_VL + 1),
  localparam int unsigned OFFW  = $clog2(MAX_VL),
  localparam int unsigned IDXW  = $clog2(MAX_VL * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic [VLW-1:0]    cfg_vl,
  input  logic [1:0]        cfg_sub,
  input  logic              ld_en,
  input  logic [OFFW-1:0]   ld_elem,
  input  logic [1:0]        ld_sub,
  input  logic              dec_valid,
  input  logic [REG_W-1:0]  dec_rd,
  input  logic [REG_W-1:0]  dec_rs1,
  input  logic [REG_W-1:0]  dec_rs2,
  input  logic [2:0]        dec_vec,
  input  logic [MAX_VL-1:0] dec_mask,
  input  logic              dec_zeroing,
  input  logic              dec_ffirst,
  output logic              busy,
  output logic              exec_valid,
  output logic [REG_W-1:0]  exec_rd,
  output logic [REG_W-1:0]  exec_rs1,
  output logic [REG_W-1:0]  exec_rs2,
  input  logic              exec_resp,
  input  logic              exec_zero,
  input  logic              exec_fault,
  output logic              zero_wr_en,
  output logic [REG_W-1:0]  zero_wr_reg,
  output logic              pc_adv,
  output logic              trap_req,
  output logic [OFFW-1:0]   elem_offs,
  output logic [1:0]        sub_offs,
  output logic [VLW-1:0]    vl_cur,
  output logic [1:0]        subvl_cur
);
  logic              rst_s_n;
  logic              cut_en;
  logic [VLW-1:0]    cut_vl;
  logic [IDXW-1:0]   flat_idx;
  logic [N_OPND-1:0] vec_flags;
  logic [REG_W-1:0]  base_arr [N_OPND];
  logic [REG_W-1:0]  opnd_arr [N_OPND];

  vseq_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  vseq_cfg #(.MAX_VL(MAX_VL), .VLW(VLW)) i_cfg (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .set_en  (cfg_en && !busy),
    .set_vl  (cfg_vl),
    .set_sub (cfg_sub),
    .cut_en  (cut_en),
    .cut_vl  (cut_vl),
    .vl_q    (vl_cur),
    .sub_q   (subvl_cur)
  );

  vseq_ctrl #(
    .MAX_VL(MAX_VL), .VLW(VLW), .OFFW(OFFW), .REG_W(REG_W), .IDXW(IDXW)
  ) i_ctrl (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .dec_valid   (dec_valid),
    .dec_rd      (dec_rd),
    .dec_rs1     (dec_rs1),
    .dec_rs2     (dec_rs2),
    .dec_vec     (dec_vec),
    .dec_mask    (dec_mask),
    .dec_zeroing (dec_zeroing),
    .dec_ffirst  (dec_ffirst),
    .cfg_en      (cfg_en),
    .ld_en       (ld_en),
    .ld_elem     (ld_elem),
    .ld_sub      (ld_sub),
    .vl          (vl_cur),
    .sub_code    (subvl_cur),
    .exec_resp   (exec_resp),
    .exec_zero   (exec_zero),
    .exec_fault  (exec_fault),
    .busy        (busy),
    .exec_valid  (exec_valid),
    .zero_wr_en  (zero_wr_en),
    .base_rd     (base_arr[0]),
    .base_rs1    (base_arr[1]),
    .base_rs2    (base_arr[2]),
    .vec_flags   (vec_flags),
    .flat_idx    (flat_idx),
    .pc_adv      (pc_adv),
    .trap_req    (trap_req),
    .elem_offs   (elem_offs),
    .sub_offs    (sub_offs),
    .cut_en      (cut_en),
    .cut_vl      (cut_vl)
  );

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    vseq_opnd #(.REG_W(REG_W), .IDXW(IDXW)) i_opnd (
      .base   (base_arr[g]),
      .is_vec (vec_flags[g]),
      .idx    (flat_idx),
      .reg_o  (opnd_arr[g])
    );
  end

  assign exec_rd     = opnd_arr[0];
  assign exec_rs1    = opnd_arr[1];
  assign exec_rs2    = opnd_arr[2];
  assign zero_wr_reg = opnd_arr[0];
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int unsigned VLW  = 4,
  parameter int unsigned OFFW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            exec_valid,
  input logic            exec_resp,
  input logic            exec_fault,
  input logic            zero_wr_en,
  input logic            pc_adv,
  input logic            trap_req,
  input logic [OFFW-1:0] elem_offs,
  input logic [1:0]      sub_offs,
  input logic [VLW-1:0]  vl_cur,
  input logic [1:0]      subvl_cur
);
  a_r1_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pc_adv);

  a_r1_pc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |=> !pc_adv);

  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_wr_en && exec_valid));

  a_r6_fault_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_valid && exec_resp && exec_fault) |=>
      (trap_req && !busy && !pc_adv && $stable(elem_offs) && $stable(sub_offs)));

  a_r7_offs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv |-> (elem_offs == '0 && sub_offs == '0));

  a_r12_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (VLW'(elem_offs) < vl_cur) && (sub_offs <= subvl_cur));
endmodule

bind vec_elem_seq vseq_chk #(.VLW(VLW), .OFFW(OFFW)) i_vseq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .exec_valid (exec_valid),
  .exec_resp  (exec_resp),
  .exec_fault (exec_fault),
  .zero_wr_en (zero_wr_en),
  .pc_adv     (pc_adv),
  .trap_req   (trap_req),
  .elem_offs  (elem_offs),
  .sub_offs   (sub_offs),
  .vl_cur     (vl_cur),
  .subvl_cur  (subvl_cur)
);

// File: tb/test_vec_elem_seq.sv
module test_vec_elem_seq;
  localparam int CLK_PERIOD = 10;
  localparam int RD_B = 10, RS1_B = 20, RS2_B = 40;

  logic clk, rst_n;
  logic cfg_en, ld_en, dec_valid, dec_zeroing, dec_ffirst;
  logic [3:0] cfg_vl;
  logic [1:0] cfg_sub, ld_sub, sub_offs, subvl_cur;
  logic [2:0] ld_elem, dec_vec, elem_offs;
  logic [6:0] dec_rd, dec_rs1, dec_rs2, exec_rd, exec_rs1, exec_rs2, zero_wr_reg;
  logic [7:0] dec_mask;
  logic busy, exec_valid, exec_resp, exec_zero, exec_fault;
  logic zero_wr_en, pc_adv, trap_req;
  logic [3:0] vl_cur;

  int nchk = 0, nerr = 0, cyc = 0;
  int last_e, last_s;

  vec_elem_seq i_vec_elem_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_vl(cfg_vl), .cfg_sub(cfg_sub),
    .ld_en(ld_en), .ld_elem(ld_elem), .ld_sub(ld_sub), .dec_valid(dec_valid),
    .dec_rd(dec_rd), .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_vec(dec_vec),
    .dec_mask(dec_mask), .dec_zeroing(dec_zeroing), .dec_ffirst(dec_ffirst),
    .busy(busy), .exec_valid(exec_valid), .exec_rd(exec_rd), .exec_rs1(exec_rs1),
    .exec_rs2(exec_rs2), .exec_resp(exec_resp), .exec_zero(exec_zero),
    .exec_fault(exec_fault), .zero_wr_en(zero_wr_en), .zero_wr_reg(zero_wr_reg),
    .pc_adv(pc_adv), .trap_req(trap_req), .elem_offs(elem_offs), .sub_offs(sub_offs),
    .vl_cur(vl_cur), .subvl_cur(subvl_cur)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
      end
    end
  end

  task automatic set_cfg(input int vl, input int sv);
    @(negedge clk);
    cfg_en = 1'b1; cfg_vl = 4'(vl); cfg_sub = 2'(sv - 1);
    @(negedge clk);
    cfg_en = 1'b0;
    chk("R11 offs cleared", int'(elem_offs) + int'(sub_offs), 0);
  endtask

  task automatic load_offs(input int e, input int s);
    @(negedge clk);
    ld_en = 1'b1; ld_elem = 3'(e); ld_sub = 2'(s);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Runs one tagged instruction; rd and rs1 are vectors, rs2 scalar.
  task automatic run_case(input int vl, input int sv, input logic [7:0] m,
                          input bit zer, input bit ff, input int zat, input int fat,
                          input int e0, input int s0);
    int e = e0, s = s0, guard = 0;
    bit done = 0, adv;
    @(negedge clk);
    dec_valid = 1'b1; dec_rd = 7'(RD_B); dec_rs1 = 7'(RS1_B); dec_rs2 = 7'(RS2_B);
    dec_vec = 3'b011; dec_mask = m; dec_zeroing = zer; dec_ffirst = ff;
    @(negedge clk);
    dec_valid = 1'b0;
    chk("R3 start elem", int'(elem_offs), e0);
    chk("R3 start sub", int'(sub_offs), s0);
    while (!done && guard < 200) begin
      int flat = e * sv + s;
      guard++;
      adv = 0;
      chk("R1 busy held", int'(busy), 1);
      chk("R1 no pc_adv", int'(pc_adv), 0);
      if (m[e]) begin
        bit isf = (flat == fat);
        bit isz = ff && (e == zat);
        chk("R8 exec_valid", int'(exec_valid), 1);
        chk("R2 rd", int'(exec_rd), (RD_B + flat) % 128);
        chk("R2 rs1", int'(exec_rs1), (RS1_B + flat) % 128);
        chk("R2 rs2 scalar", int'(exec_rs2), RS2_B);
        exec_resp = 1'b1; exec_fault = isf; exec_zero = (e == zat);
        @(negedge clk);
        exec_resp = 1'b0; exec_fault = 1'b0; exec_zero = 1'b0;
        if (isf) begin
          chk("R6 trap", int'(trap_req), 1);
          chk("R6 busy low", int'(busy), 0);
          chk("R6 no pc_adv", int'(pc_adv), 0);
          chk("R6 elem kept", int'(elem_offs), e);
          chk("R6 sub kept", int'(sub_offs), s);
          last_e = e; last_s = s;
          done = 1;
        end else if (isz) begin
          chk("R9 pc_adv", int'(pc_adv), 1);
          chk("R9 vl cut", int'(vl_cur), (e == 0) ? 1 : e);
          chk("R7 offs zero", int'(elem_offs) + int'(sub_offs), 0);
          done = 1;
        end else adv = 1;
      end else if (zer) begin
        chk("R5 zero_wr_en", int'(zero_wr_en), 1);
        chk("R5 zero_wr_reg", int'(zero_wr_reg), (RD_B + flat) % 128);
        chk("R5 no exec", int'(exec_valid), 0);
        @(negedge clk);
        adv = 1;
      end else begin
        chk("R4 no exec", int'(exec_valid), 0);
        chk("R4 no zero wr", int'(zero_wr_en), 0);
        @(negedge clk);
        s = sv - 1;
        adv = 1;
      end
      if (adv) begin
        if (s == sv - 1) begin s = 0; e++; end
        else s++;
        if (e == vl) begin
          chk("R1 pc_adv", int'(pc_adv), 1);
          chk("R1 busy low", int'(busy), 0);
          chk("R7 elem zero", int'(elem_offs), 0);
          chk("R7 sub zero", int'(sub_offs), 0);
          chk("R9 vl kept", int'(vl_cur), vl);
          done = 1;
        end
      end
    end
    chk("loop ended", int'(done), 1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_en = 0; ld_en = 0; dec_valid = 0; cfg_vl = 0; cfg_sub = 0;
    ld_elem = 0; ld_sub = 0; dec_rd = 0; dec_rs1 = 0; dec_rs2 = 0; dec_vec = 0;
    dec_mask = 0; dec_zeroing = 0; dec_ffirst = 0;
    exec_resp = 0; exec_zero = 0; exec_fault = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset pc_adv", int'(pc_adv), 0);
    chk("R6 reset trap", int'(trap_req), 0);
    chk("R7 reset offs", int'(elem_offs) + int'(sub_offs), 0);
    chk("R11 reset vl", int'(vl_cur), 1);

    // R8 R4 R5 sweep over lengths, group sizes, masks and zeroing
    for (int vl = 1; vl <= 4; vl++)
      for (int sv = 1; sv <= 3; sv++)
        for (int mi = 0; mi < 4; mi++)
          for (int z = 0; z < 2; z++) begin
            logic [7:0] m = (mi == 0) ? 8'hFF : (mi == 1) ? 8'hA5 :
                            (mi == 2) ? 8'h5A : 8'h00;
            set_cfg(vl, sv);
            run_case(vl, sv, m, z[0], 1'b0, -1, -1, 0, 0);
          end

    // R10 scalar case
    set_cfg(1, 1);
    run_case(1, 1, 8'h01, 1'b0, 1'b0, -1, -1, 0, 0);

    // R9 zero without fail-on-first is ignored, then cuts at 2 and at 0
    set_cfg(4, 2);
    run_case(4, 2, 8'hFF, 1'b0, 1'b0, 1, -1, 0, 0);
    run_case(4, 2, 8'hFF, 1'b0, 1'b1, 2, -1, 0, 0);
    set_cfg(4, 2);
    run_case(4, 2, 8'hFF, 1'b0, 1'b1, 0, -1, 0, 0);

    // R6 fault then R3 resume from the kept offsets
    set_cfg(4, 2);
    run_case(4, 2, 8'hFF, 1'b0, 1'b0, -1, 5, 0, 0);
    run_case(4, 2, 8'hFF, 1'b0, 1'b0, -1, -1, last_e, last_s);

    // R12 offset load and clamp, R3 resume from loaded offsets
    set_cfg(4, 1);
    load_offs(2, 0);
    chk("R12 elem load", int'(elem_offs), 2);
    run_case(4, 1, 8'hFF, 1'b1, 1'b0, -1, -1, 2, 0);
    set_cfg(4, 2);
    load_offs(7, 3);
    chk("R12 elem clamp", int'(elem_offs), 3);
    chk("R12 sub clamp", int'(sub_offs), 1);
    set_cfg(4, 2);
    chk("R11 elem cleared", int'(elem_offs), 0);

    // R11 length clamping
    set_cfg(0, 1);
    chk("R11 vl low clamp", int'(vl_cur), 1);
    set_cfg(12, 4);
    chk("R11 vl high clamp", int'(vl_cur), 8);
    chk("R11 sub code", int'(subvl_cur), 3);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule